// File: doc/BRIEF.md
# Two-Wire Handshake Word Link

This block moves 16-bit words from a local producer to a local consumer across a set of point-to-point wires. The wires are sixteen data lines and two control lines. A ready line, active high, runs from the receiving end to the sending end. A strobe line, active low, runs from the sending end to the receiving end. The block contains both ends of the link. Each end samples the control line coming from the far end through a two-stage synchronizer, so the two ends could sit in separate timing regions. The three link wires are also brought out as ports so that the link can be observed.

The sending end takes one word from a valid/ready push port, waits until the far end reports ready, puts the word on the data lines, and only then pulls the strobe low. It lets the strobe go high again once it sees ready fall. It refuses further pushes while a word is in flight. The receiving end detects the falling edge of its synchronized strobe, latches the data lines into its input register, drops ready and gives a one-cycle arrival pulse. It offers the word on a valid/ready pop port. Ready goes high again only after the consumer has taken the word and the strobe has been seen inactive.

On both user ports a transfer happens on a clock edge where valid and ready are both high. A producer that sees `in_ready` low must wait: the block takes nothing while that pin is low. The consumer applies back-pressure by holding `out_ready` low. The word then stays parked in the input register, ready stays low and the sending end stalls.

Top module: `hsx_link`

## Requirements
- R1: After reset, `wire_rdy` is 1, `wire_strobe_n` is 1 (inactive), `in_ready` is 1 and `out_valid` is 0.
- R2: A word is accepted only on an edge where `in_valid` and `in_ready` are both 1. `in_ready` is 0 from the cycle after acceptance until the sender has released the strobe. A push offered while `in_ready` is 0 is ignored and never reaches `out_data`.
- R3: `wire_strobe_n` falls only while the sender's synchronized view of ready is high, and `wire_data` already carries the word in the cycle before the fall.
- R4: While `wire_strobe_n` is 0, `wire_data` does not change.
- R5: After a falling edge of the strobe, the receiver raises `out_valid` with `out_data` equal to the word the sender drove, and drops `wire_rdy`.
- R6: While `out_valid` is 1, `wire_rdy` is 0. While `out_valid` is 1 and `out_ready` is 0, `out_data` holds and `out_valid` stays 1.
- R7: `wire_rdy` rises only when `wire_strobe_n` is 1, after the consumer has popped the word.
- R8: The sender raises `wire_strobe_n` only after it has seen ready low. It does not pull the strobe low again until it has seen ready high again.
- R9: Words reach `out_data` in push order, each exactly once, for any pop delay.
- R10: `word_arrived` is a single-cycle pulse, given once per captured word.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for both ends |
| rst_n | input | 1 | Asynchronous reset, active low |
| in_valid | input | 1 | Producer offers a word |
| in_ready | output | 1 | Sender is idle and can take a word |
| in_data | input | 16 | Word to send |
| out_valid | output | 1 | Captured word is available |
| out_ready | input | 1 | Consumer takes the word |
| out_data | output | 16 | Captured word |
| word_arrived | output | 1 | One-cycle pulse when a word is latched |
| wire_data | output | 16 | Link data lines |
| wire_rdy | output | 1 | Link ready line, receiver to sender, active high |
| wire_strobe_n | output | 1 | Link data-valid line, sender to receiver, active low |

## Verification
The hardest case is a second word pushed while the first is still parked in the input register. In that case the sender has already gone idle, accepted a new word, and stalls waiting for ready. The receiver's drain state then decides when ready may return. The stimulus reaches this case by pushing several words back to back from one thread, while a separate thread pops them with pop delays that range from zero to several cycles. An observer checks strobe and ready edges against each other on every cycle throughout the run.

// File: rtl/hsx_pkg.sv
package hsx_pkg;
  typedef enum logic [1:0] {
    TX_IDLE   = 2'd0,
    TX_WAIT   = 2'd1,
    TX_SETUP  = 2'd2,
    TX_STROBE = 2'd3
  } tx_state_e;

  typedef enum logic [1:0] {
    RX_OPEN  = 2'd0,
    RX_FULL  = 2'd1,
    RX_DRAIN = 2'd2
  } rx_state_e;
endpackage

// File: rtl/hsx_sync.sv
module hsx_sync #(
  parameter int   STAGES  = 2,
  parameter logic RST_VAL = 1'b0
) (
  input  logic clk,
  input  logic rst_n,
  input  logic d,
  output logic q
);
  logic [STAGES-1:0] chain;

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[0] <= RST_VAL;
          else        chain[0] <= d;
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n)
          if (!rst_n) chain[i] <= RST_VAL;
          else        chain[i] <= chain[i-1];
      end
    end
  endgenerate

  assign q = chain[STAGES-1];
endmodule

// File: rtl/hsx_sender.sv
module hsx_sender
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  input  logic              rdy_in,
  output logic [DATA_W-1:0] data_out,
  output logic              strobe_n
);
  tx_state_e         state;
  logic [DATA_W-1:0] word_q;
  logic              rdy_s;

  hsx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b0)) u_rdy_sync (
    .clk(clk), .rst_n(rst_n), .d(rdy_in), .q(rdy_s)
  );

  assign in_ready = (state == TX_IDLE);
  assign data_out = word_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state    <= TX_IDLE;
      word_q   <= '0;
      strobe_n <= 1'b1;
    end else begin
      unique case (state)
        TX_IDLE: if (in_valid) begin
          word_q <= in_data;
          state  <= TX_WAIT;
        end
        TX_WAIT:  if (rdy_s) state <= TX_SETUP;
        TX_SETUP: if (rdy_s) begin
          strobe_n <= 1'b0;
          state    <= TX_STROBE;
        end
        TX_STROBE: if (!rdy_s) begin
          strobe_n <= 1'b1;
          state    <= TX_IDLE;
        end
        default: state <= TX_IDLE;
      endcase
    end
  end

  // R3: strobe falls only with ready seen high, data already on the lines
  p_strobe_after_rdy_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(strobe_n) |-> ($past(rdy_s) && $stable(data_out)));
  // R4: data lines frozen while strobe is active
  p_data_hold_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (!strobe_n && !$past(strobe_n)) |-> $stable(data_out));
  // R8: strobe released only after ready seen low
  p_release_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(strobe_n) |-> !$past(rdy_s));
  // R2: a busy sender keeps its word
  p_busy_ignores_r2: assert property (@(posedge clk) disable iff (!rst_n)
    !in_ready |=> $stable(data_out));
endmodule

// File: rtl/hsx_receiver.sv
module hsx_receiver
  import hsx_pkg::*;
#(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [DATA_W-1:0] data_in,
  input  logic              strobe_n_in,
  output logic              rdy_out,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              arrived
);
  rx_state_e         state;
  logic [DATA_W-1:0] cap_q;
  logic              strobe_s, strobe_prev, strobe_fall;

  hsx_sync #(.STAGES(SYNC_STAGES), .RST_VAL(1'b1)) u_strobe_sync (
    .clk(clk), .rst_n(rst_n), .d(strobe_n_in), .q(strobe_s)
  );

  assign strobe_fall = strobe_prev & ~strobe_s;
  assign rdy_out     = (state == RX_OPEN);
  assign out_valid   = (state == RX_FULL);
  assign out_data    = cap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state       <= RX_OPEN;
      cap_q       <= '0;
      strobe_prev <= 1'b1;
      arrived     <= 1'b0;
    end else begin
      strobe_prev <= strobe_s;
      arrived     <= 1'b0;
      unique case (state)
        RX_OPEN: if (strobe_fall) begin
          cap_q   <= data_in;
          arrived <= 1'b1;
          state   <= RX_FULL;
        end
        RX_FULL:  if (out_ready) state <= strobe_s ? RX_OPEN : RX_DRAIN;
        RX_DRAIN: if (strobe_s)  state <= RX_OPEN;
        default:  state <= RX_OPEN;
      endcase
    end
  end

  // R6: ready low while a word is held
  p_rdy_low_full_r6: assert property (@(posedge clk) disable iff (!rst_n)
    out_valid |-> !rdy_out);
  // R6: held word is stable under back-pressure
  p_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (out_valid && !out_ready) |=> (out_valid && $stable(out_data)));
  // R7: ready returns only with the strobe seen inactive
  p_rdy_rise_r7: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rdy_out) |-> $past(strobe_s));
  // R10: arrival notice lasts one cycle
  p_pulse_r10: assert property (@(posedge clk) disable iff (!rst_n)
    arrived |=> !arrived);
endmodule

// File: rtl/hsx_link.sv
module hsx_link #(
  parameter int DATA_W      = 16,
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              in_valid,
  output logic              in_ready,
  input  logic [DATA_W-1:0] in_data,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [DATA_W-1:0] out_data,
  output logic              word_arrived,
  output logic [DATA_W-1:0] wire_data,
  output logic              wire_rdy,
  output logic              wire_strobe_n
);
  hsx_sender #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_tx (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .rdy_in(wire_rdy), .data_out(wire_data), .strobe_n(wire_strobe_n)
  );

  hsx_receiver #(.DATA_W(DATA_W), .SYNC_STAGES(SYNC_STAGES)) u_rx (
    .clk(clk), .rst_n(rst_n),
    .data_in(wire_data), .strobe_n_in(wire_strobe_n), .rdy_out(wire_rdy),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .arrived(word_arrived)
  );
endmodule

// File: tb/tb_hsx_link.sv
module tb_hsx_link;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        in_valid = 1'b0;
  logic        in_ready;
  logic [15:0] in_data = '0;
  logic        out_valid;
  logic        out_ready = 1'b0;
  logic [15:0] out_data;
  logic        word_arrived;
  logic [15:0] wire_data;
  logic        wire_rdy;
  logic        wire_strobe_n;

  int  tests = 0;
  int  fails = 0;
  int  arrivals = 0;
  int  pops = 0;
  bit  finished = 1'b0;
  bit  mon_en = 1'b0;

  logic [15:0] exp_q[$];

  always #2.5 clk = ~clk;

  hsx_link dut (
    .clk(clk), .rst_n(rst_n),
    .in_valid(in_valid), .in_ready(in_ready), .in_data(in_data),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .word_arrived(word_arrived),
    .wire_data(wire_data), .wire_rdy(wire_rdy), .wire_strobe_n(wire_strobe_n)
  );

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  // Observer of the link wires, sampled at the falling clock edge
  logic        p_rdy = 1'b1, p_strobe = 1'b1, p_arr = 1'b0;
  logic [15:0] p_data = '0;
  always @(negedge clk) begin
    if (mon_en) begin
      if (p_strobe && !wire_strobe_n) begin
        chk(p_rdy && wire_rdy, "R8 strobe fell without ready high", {31'b0, wire_rdy}, 1);
        chk(wire_data == p_data, "R3 data not set up before strobe", wire_data, p_data);
      end
      if (!p_strobe && !wire_strobe_n)
        chk(wire_data == p_data, "R4 data moved under strobe", wire_data, p_data);
      if (!p_rdy && wire_rdy)
        chk(wire_strobe_n, "R7 ready rose with strobe active", {31'b0, wire_strobe_n}, 1);
      if (out_valid)
        chk(!wire_rdy, "R6 ready high while word held", {31'b0, wire_rdy}, 0);
      if (p_arr && word_arrived)
        chk(1'b0, "R10 arrival pulse longer than one cycle", 1, 0);
      if (word_arrived) arrivals++;
      p_rdy    = wire_rdy;
      p_strobe = wire_strobe_n;
      p_data   = wire_data;
      p_arr    = word_arrived;
    end
  end

  task automatic push_word(input logic [15:0] w);
    int n = 0;
    while (!in_ready && n < 200) begin @(negedge clk); n++; end
    in_valid = 1'b1;
    in_data  = w;
    exp_q.push_back(w);
    @(negedge clk);
    in_valid = 1'b0;
    chk(!in_ready, "R2 in_ready high right after accept", {31'b0, in_ready}, 0);
  endtask

  task automatic pop_word(input int delay);
    int n = 0;
    logic [15:0] e;
    while (!out_valid && n < 200) begin @(negedge clk); n++; end
    e = (exp_q.size() > 0) ? exp_q.pop_front() : 16'hdead;
    chk(out_valid, "R5 no word arrived", {31'b0, out_valid}, 1);
    chk(out_data == e, "R9 word value or order", out_data, e);
    for (int k = 0; k < delay; k++) begin
      @(negedge clk);
      chk(out_valid && out_data == e, "R6 held word changed", out_data, e);
    end
    out_ready = 1'b1;
    @(negedge clk);
    out_ready = 1'b0;
    pops++;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      fails++;
      tests++;
      $display("FAIL R9 watchdog expired actual=hung expected=done");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    // R1 reset state
    chk(wire_rdy == 1'b1,      "R1 rdy after reset",    {31'b0, wire_rdy}, 1);
    chk(wire_strobe_n == 1'b1, "R1 strobe after reset", {31'b0, wire_strobe_n}, 1);
    chk(in_ready == 1'b1,      "R1 in_ready after reset", {31'b0, in_ready}, 1);
    chk(out_valid == 1'b0,     "R1 out_valid after reset", {31'b0, out_valid}, 0);
    p_data = wire_data;
    mon_en = 1'b1;
    repeat (4) @(negedge clk);

    // R5, R9: walking ones and zeros, serial
    for (int i = 0; i < 16; i++) begin
      push_word(16'h1 << i);
      pop_word(i % 3);
      push_word(~(16'h1 << i));
      pop_word(0);
    end

    // R9: arithmetic sweep with pop delays 0..6
    for (int i = 0; i < 300; i++) begin
      push_word(16'((i * 40503) ^ (i << 5)));
      pop_word(i % 7);
    end

    // R2: pushes while busy are ignored
    push_word(16'hA55A);
    in_valid = 1'b1;
    in_data  = 16'h0FF0;
    for (int k = 0; k < 3; k++) begin
      chk(!in_ready, "R2 in_ready while busy", {31'b0, in_ready}, 0);
      @(negedge clk);
    end
    in_valid = 1'b0;
    pop_word(2);
    repeat (40) @(negedge clk);
    chk(!out_valid, "R2 ignored push was delivered", {31'b0, out_valid}, 0);

    // R9, R6: producer runs ahead while consumer stalls
    fork
      begin
        for (int i = 0; i < 40; i++) push_word(16'(16'hC000 + i * 777));
      end
      begin
        for (int i = 0; i < 40; i++) pop_word((i * 5) % 9);
      end
    join
    repeat (40) @(negedge clk);
    chk(!out_valid, "R9 extra word delivered", {31'b0, out_valid}, 0);
    chk(exp_q.size() == 0, "R9 words lost", exp_q.size(), 0);
    chk(arrivals == pops, "R10 arrival pulses per word", arrivals, pops);
    chk(wire_rdy && wire_strobe_n, "R8 link not idle at end",
        {30'b0, wire_rdy, wire_strobe_n}, 3);

    finished = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule